// File: doc/BRIEF.md
# Two-Wire Bus Condition and Arbitration Monitor

This block observes the data and clock lines of an open-drain two-wire serial bus (I2C style). It does not drive them. Both raw line levels are brought into the system clock domain. It then reports bus framing events as single-cycle pulses: a START when data falls while the clock line stays high, and a STOP when data rises while the clock line stays high. A busy flag records that a transfer is open, from a START until the next STOP.

A local bus master tells the monitor whether it is currently driving the data line and at what level. A line that is released reads high through the pull-up, so the sampled level is the wired-AND of every driver on the bus. The master has lost arbitration if it releases the data line (intends a 1) while the clock line is high and the data line nevertheless reads low. That loss is latched and stays reported until the next START or STOP. The monitor also pulses a protocol-error output in two cases: data and clock change in the same sample, or a STOP appears while no transfer is open.

All outputs are registered. A change on the raw lines reaches the outputs three clock edges later when the default configuration is used (two synchronizer flops plus the output register). Parameters set the synchronizer depth, an optional glitch filter, and whether an orphan STOP counts as an error.

Top module: `twowire_bus_watch`

## Requirements
- R1: After reset, start_pulse, stop_pulse, illegal_pulse, bus_busy and arb_lost are all 0, and both lines are assumed high (idle).
- R2: start_pulse is high for exactly one cycle when the sampled data line goes 1→0 while the sampled clock line is 1 in both the previous and the current sample.
- R3: stop_pulse is high for exactly one cycle when the sampled data line goes 0→1 while the sampled clock line is 1 in both the previous and the current sample.
- R4: bus_busy rises together with a start_pulse and falls together with a stop_pulse. A further START while busy (a repeated START) leaves it set.
- R5: A data-line change while the clock line is 0 in both samples produces no start_pulse, stop_pulse or illegal_pulse.
- R6: illegal_pulse is high for one cycle when the data and clock lines both change between two consecutive samples.
- R7: With ORPHAN_STOP_ERR=1 (default), a STOP seen while bus_busy is 0 raises a one-cycle illegal_pulse, and stop_pulse is still reported.
- R8: arb_lost is set when drv_en=1, drv_level=1, the sampled clock line is 1 and the sampled data line is 0.
- R9: arb_lost is not set when drv_en=0, when drv_level=0, or when the sampled clock line is 0.
- R10: arb_lost holds until a START or STOP is detected. If the loss condition holds in the same cycle as that START or STOP, arb_lost stays set.
- R11: start_pulse and stop_pulse are never high in the same cycle, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_raw | input | 1 | Raw data line level from the pad |
| scl_raw | input | 1 | Raw clock line level from the pad |
| drv_level | input | 1 | Level the local master intends on the data line (1 = released) |
| drv_en | input | 1 | Local master is taking part on the data line |
| start_pulse | output | 1 | One-cycle START indication |
| stop_pulse | output | 1 | One-cycle STOP indication |
| illegal_pulse | output | 1 | One-cycle protocol-error indication |
| bus_busy | output | 1 | A transfer is open on the bus |
| arb_lost | output | 1 | Local master lost arbitration (sticky) |

## Verification
Two functions can fire in the same cycle: START detection and the arbitration-loss check. This happens when another master pulls the data line low while the clock line is high, and the local master is at that moment releasing it with drv_en set. The bench provokes this through a sweep. It takes every pair of line states (from and to) under every drv_en/drv_level combination. At each step, a bench model of the line history predicts the exact number of start, stop and error pulses and the final busy and loss flags. The case where a START clears the loss flag and also sets it in the same cycle is judged by requiring arb_lost to remain 1 afterwards.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // Sampled bus line pair.
   typedef struct packed {
      logic scl;
      logic sda;
   } tw_line_t;

   localparam tw_line_t TW_IDLE = '{scl: 1'b1, sda: 1'b1};

   // Decoded framing events for one sample.
   typedef struct packed {
      logic open_xfer;
      logic close_xfer;
      logic skew_err;
      logic orphan_err;
   } tw_event_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("tw_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("tw_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= '1;
            else        chain[0] <= d_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '1;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign d_out = chain[LAST];

endmodule

// File: rtl/tw_deglitch.sv
module tw_deglitch #(
   parameter int LEN   = 0,
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   if (LEN < 0) begin : g_bad_len
      $error("tw_deglitch: LEN must not be negative");
   end

   if (LEN == 0) begin : g_bypass
      assign d_out = d_in;
   end else begin : g_filter
      localparam int CW = $clog2(LEN) + 1;
      localparam logic [CW-1:0] LIMIT = CW'(LEN - 1);

      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [CW-1:0] run_cnt;
         logic          held;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held    <= 1'b1;
               run_cnt <= '0;
            end else if (d_in[b] == held) begin
               run_cnt <= '0;
            end else if (run_cnt == LIMIT) begin
               held    <= d_in[b];
               run_cnt <= '0;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end

         assign d_out[b] = held;
      end
   end

endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
   import tw_pkg::*;
#(
   parameter bit ORPHAN_STOP_ERR = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  tw_line_t cur,
   output logic     frame_edge,
   output logic     start_q,
   output logic     stop_q,
   output logic     illegal_q,
   output logic     busy_q
);

   tw_line_t  prev;
   tw_event_t ev;
   logic      clk_held_high;
   logic      dat_fell;
   logic      dat_rose;
   logic      busy_d;

   assign clk_held_high = cur.scl & prev.scl;
   assign dat_fell      = prev.sda & ~cur.sda;
   assign dat_rose      = ~prev.sda & cur.sda;

   assign ev.open_xfer  = clk_held_high & dat_fell;
   assign ev.close_xfer = clk_held_high & dat_rose;
   assign ev.skew_err   = (cur.scl ^ prev.scl) & (cur.sda ^ prev.sda);

   if (ORPHAN_STOP_ERR) begin : g_orphan_on
      assign ev.orphan_err = ev.close_xfer & ~busy_q;
   end else begin : g_orphan_off
      assign ev.orphan_err = 1'b0;
   end

   always_comb begin
      busy_d = busy_q;
      if (ev.open_xfer)       busy_d = 1'b1;
      else if (ev.close_xfer) busy_d = 1'b0;
   end

   assign frame_edge = ev.open_xfer | ev.close_xfer;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev      <= TW_IDLE;
         start_q   <= 1'b0;
         stop_q    <= 1'b0;
         illegal_q <= 1'b0;
         busy_q    <= 1'b0;
      end else begin
         prev      <= cur;
         start_q   <= ev.open_xfer;
         stop_q    <= ev.close_xfer;
         illegal_q <= ev.skew_err | ev.orphan_err;
         busy_q    <= busy_d;
      end
   end

endmodule

// File: rtl/tw_arb_track.sv
module tw_arb_track
   import tw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  tw_line_t cur,
   input  logic     drv_en,
   input  logic     drv_level,
   input  logic     frame_edge,
   output logic     lost_q
);

   logic mismatch;

   // Released (intends 1) at the sampling point, but the wire reads 0.
   assign mismatch = drv_en & drv_level & cur.scl & ~cur.sda;

   always_ff @(posedge clk) begin
      if (!rst_n) lost_q <= 1'b0;
      else        lost_q <= mismatch | (lost_q & ~frame_edge);
   end

endmodule

// File: rtl/twowire_bus_watch.sv
module twowire_bus_watch
   import tw_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int FILTER_LEN      = 0,
   parameter bit ORPHAN_STOP_ERR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_raw,
   input  logic scl_raw,
   input  logic drv_level,
   input  logic drv_en,
   output logic start_pulse,
   output logic stop_pulse,
   output logic illegal_pulse,
   output logic bus_busy,
   output logic arb_lost
);

   localparam int LINES = $bits(tw_line_t);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("twowire_bus_watch: SYNC_STAGES must be at least 2");
   end
   if (FILTER_LEN < 0) begin : g_bad_filter
      $error("twowire_bus_watch: FILTER_LEN must not be negative");
   end

   logic [LINES-1:0] raw_vec;
   logic [LINES-1:0] sync_vec;
   logic [LINES-1:0] clean_vec;
   tw_line_t         line_now;
   logic             frame_edge;

   assign raw_vec = {scl_raw, sda_raw};

   tw_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (LINES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_vec),
      .d_out (sync_vec)
   );

   tw_deglitch #(
      .LEN   (FILTER_LEN),
      .WIDTH (LINES)
   ) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (sync_vec),
      .d_out (clean_vec)
   );

   assign line_now = tw_line_t'(clean_vec);

   tw_cond_detect #(
      .ORPHAN_STOP_ERR (ORPHAN_STOP_ERR)
   ) u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur        (line_now),
      .frame_edge (frame_edge),
      .start_q    (start_pulse),
      .stop_q     (stop_pulse),
      .illegal_q  (illegal_pulse),
      .busy_q     (bus_busy)
   );

   tw_arb_track u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur        (line_now),
      .drv_en     (drv_en),
      .drv_level  (drv_level),
      .frame_edge (frame_edge),
      .lost_q     (arb_lost)
   );

endmodule

// File: rtl/twowire_bus_watch_chk.sv
module twowire_bus_watch_chk (
   input logic clk,
   input logic rst_n,
   input logic drv_level,
   input logic drv_en,
   input logic start_pulse,
   input logic stop_pulse,
   input logic illegal_pulse,
   input logic bus_busy,
   input logic arb_lost
);

   assert_start_stop_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && stop_pulse));

   assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   assert_stop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |=> !stop_pulse);

   assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_busy) |-> start_pulse);

   assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_busy) |-> stop_pulse);

   assert_start_keeps_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> bus_busy);

   assert_illegal_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_pulse |=> !illegal_pulse);

   assert_arb_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> $past(drv_en && drv_level));

   assert_arb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(arb_lost) |-> (start_pulse || stop_pulse));

endmodule

bind twowire_bus_watch twowire_bus_watch_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .drv_level     (drv_level),
   .drv_en        (drv_en),
   .start_pulse   (start_pulse),
   .stop_pulse    (stop_pulse),
   .illegal_pulse (illegal_pulse),
   .bus_busy      (bus_busy),
   .arb_lost      (arb_lost)
);

// File: tb/test_twowire_bus_watch.sv
`timescale 1ns/1ps
module test_twowire_bus_watch;

   localparam int WIN      = 8;
   localparam int WDOG_CYC = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sda_raw = 1'b1;
   logic scl_raw = 1'b1;
   logic drv_level = 1'b0;
   logic drv_en = 1'b0;
   logic start_pulse, stop_pulse, illegal_pulse, bus_busy, arb_lost;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Bench model of the bus history
   logic m_scl = 1'b1, m_sda = 1'b1, m_busy = 1'b0, m_lost = 1'b0;

   always #2.5 clk = ~clk;

   twowire_bus_watch i_twowire_bus_watch (
      .clk           (clk),
      .rst_n         (rst_n),
      .sda_raw       (sda_raw),
      .scl_raw       (scl_raw),
      .drv_level     (drv_level),
      .drv_en        (drv_en),
      .start_pulse   (start_pulse),
      .stop_pulse    (stop_pulse),
      .illegal_pulse (illegal_pulse),
      .bus_busy      (bus_busy),
      .arb_lost      (arb_lost)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // Move the bus lines, then count output pulses over a window.
   task automatic bus_step(input logic c, input logic d);
      logic pc, pd, st, sp, ill, cond;
      int   cs, cp, ci;
      pc = m_scl; pd = m_sda;
      st  = pc & c & pd & ~d;
      sp  = pc & c & ~pd & d;
      ill = ((pc ^ c) & (pd ^ d)) | (sp & ~m_busy);
      cond = drv_en & drv_level & c & ~d;
      cs = 0; cp = 0; ci = 0;
      @(negedge clk);
      scl_raw = c; sda_raw = d;
      for (int k = 0; k < WIN; k++) begin
         @(negedge clk);
         cs += int'(start_pulse);
         cp += int'(stop_pulse);
         ci += int'(illegal_pulse);
      end
      if (st) m_busy = 1'b1;
      else if (sp) m_busy = 1'b0;
      m_lost = cond | (m_lost & ~(st | sp));
      m_scl = c; m_sda = d;
      check("R2/R11 start count", cs, int'(st));
      check("R3/R11 stop count", cp, int'(sp));
      check("R6/R7 illegal count", ci, int'(ill));
      check("R4 busy", int'(bus_busy), int'(m_busy));
      check("R8/R9/R10 arb_lost", int'(arb_lost), int'(m_lost));
      if (!pc && !c) check("R5 no events with clock low", cs + cp + ci, 0);
   endtask

   // Change the local drive with the bus held still.
   task automatic set_drive(input logic en, input logic lvl);
      @(negedge clk);
      drv_en = en; drv_level = lvl;
      repeat (WIN) @(negedge clk);
      m_lost = m_lost | (en & lvl & m_scl & ~m_sda);
      check("R8/R9 arb_lost after drive change", int'(arb_lost), int'(m_lost));
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 start_pulse", int'(start_pulse), 0);
      check("R1 stop_pulse", int'(stop_pulse), 0);
      check("R1 illegal_pulse", int'(illegal_pulse), 0);
      check("R1 bus_busy", int'(bus_busy), 0);
      check("R1 arb_lost", int'(arb_lost), 0);
      rst_n = 1'b1;
      repeat (WIN) @(negedge clk);
      check("R1 idle after release", int'(start_pulse | stop_pulse | illegal_pulse | bus_busy | arb_lost), 0);

      // Directed: frame with repeated START (R4), then a STOP on idle bus (R7)
      bus_step(1'b1, 1'b0);   // START
      bus_step(1'b0, 1'b0);
      bus_step(1'b0, 1'b1);   // data change, clock low (R5)
      bus_step(1'b1, 1'b1);
      bus_step(1'b1, 1'b0);   // repeated START, busy stays (R4)
      bus_step(1'b0, 1'b0);
      bus_step(1'b1, 1'b0);
      bus_step(1'b1, 1'b1);   // STOP
      bus_step(1'b1, 1'b0);   // START
      bus_step(1'b1, 1'b1);   // STOP
      bus_step(1'b0, 1'b1);
      bus_step(1'b0, 1'b0);
      bus_step(1'b1, 1'b0);
      bus_step(1'b1, 1'b1);   // orphan STOP while idle (R7)

      // Directed R10: other master's START while local master releases the line
      set_drive(1'b1, 1'b1);
      bus_step(1'b1, 1'b0);   // START and loss in the same cycle: loss stays
      check("R10 loss kept across simultaneous START", int'(arb_lost), 1);
      set_drive(1'b0, 1'b0);
      bus_step(1'b1, 1'b1);   // STOP clears loss
      check("R10 loss cleared by STOP", int'(arb_lost), 0);

      // Sweep: every drive combination x every from/to line pair
      for (int e = 0; e < 4; e++) begin
         for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
               bus_step(f[1], f[0]);
               set_drive(e[1], e[0]);
               bus_step(t[1], t[0]);
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule